// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built from identical four-bit stages. Each stage can be preset from a data word, and it advances only when two separate count enables are both asserted. One enable (the parallel enable) is shared by every stage. The other (the trickle enable) passes from stage to stage through each stage's terminal-count signal. A chain of N stages therefore counts modulo 16^N, and every stage uses the one clock.

The reset style is chosen when the block is built. In the asynchronous variant, a low reset clears the count at once, without waiting for a clock edge. In the synchronous variant, a low reset clears the count on the next rising clock edge. The modes have a fixed precedence: clear, then load, then count, then hold.

Top module: `cascade_counter`

## Requirements
- R1: Each four-bit stage counts modulo 16, going from 15 to 0. The whole chain goes from all ones to all zeros on the next count.
- R2: The modes have a fixed precedence: reset, then load, then count, then hold. A low `rst_n` clears the count even when `load_n` is low.
- R3: With ASYNC_RST=1, a low `rst_n` forces `count_out` to zero at once, with no clock edge, and overrides every other input.
- R4: With ASYNC_RST=0, a low `rst_n` clears `count_out` on the next rising edge of `clk` and not before.
- R5: When `load_n` is low and reset is inactive, `data_in` is loaded on the rising edge, whatever `cnt_en_p` and `cnt_en_t` are.
- R6: The count rises by one on a rising edge only when `load_n`, `cnt_en_p` and `cnt_en_t` are all high. If either enable is low, the count holds.
- R7: `carry_out` is high exactly when `cnt_en_t` is high and every bit of `count_out` is 1. It follows `cnt_en_t` with no clock edge.
- R8: Each stage's terminal count feeds the trickle enable of the next stage. The chain therefore carries correctly, for example from 0x0F to 0x10.
- R9: Apart from the asynchronous reset, `count_out` changes only on a rising edge of `clk`. A change on `data_in`, `load_n` or the enables between edges does not move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset; its style is set by ASYNC_RST |
| load_n | input | 1 | Active-low preset strobe |
| cnt_en_p | input | 1 | Count enable shared by all stages |
| cnt_en_t | input | 1 | Trickle count enable of the first stage |
| data_in | input | STAGE_W*STAGES | Preset value, with the least significant stage in the low bits |
| count_out | output | STAGE_W*STAGES | Current count |
| carry_out | output | 1 | Terminal count of the last stage |

## Verification
A wrong stage register or a wrong mode decision shows as a `count_out` value that differs from a plain integer model on the very next rising edge. A broken link in the trickle chain stays hidden until the lower stage reaches 15. It then shows as a missing or early carry within one clock. `carry_out` is also compared between edges, so a terminal count that waits for a clock instead of following `cnt_en_t` shows in the same cycle. The asynchronous clear is checked a few nanoseconds after `rst_n` falls, well before the next edge.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2,
        MODE_CLEAR = 2'd3
    } cnt_mode_e;

    typedef struct packed {
        logic load_n;
        logic cen_p;
        logic cen_t;
    } stage_ctl_t;

    // Fixed precedence: clear, load, count, hold.
    function automatic cnt_mode_e pick_mode(input logic clr, input stage_ctl_t c);
        if (clr)
            return MODE_CLEAR;
        else if (!c.load_n)
            return MODE_LOAD;
        else if (c.cen_p && c.cen_t)
            return MODE_COUNT;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
    import cascade_counter_pkg::*;
#(
    parameter bit ASYNC_RST = 1'b0
) (
    input  logic       rst_n,
    input  stage_ctl_t ctl,
    output cnt_mode_e  mode
);
    // The asynchronous variant clears in the flop itself, so no clear mode is decoded here.
    logic clr_req;

    generate
        if (ASYNC_RST) begin : g_async
            assign clr_req = 1'b0;
        end else begin : g_sync
            assign clr_req = ~rst_n;
        end
    endgenerate

    assign mode = pick_mode(clr_req, ctl);

endmodule

// File: rtl/cnt_nibble_stage.sv
module cnt_nibble_stage
    import cascade_counter_pkg::*;
#(
    parameter int W         = 4,
    parameter bit ASYNC_RST = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] d,
    input  logic         cet,
    output logic [W-1:0] q,
    output logic         tc
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE      = W'(1);

    logic [W-1:0] q_nxt;

    always_comb begin
        unique case (mode)
            MODE_CLEAR: q_nxt = '0;
            MODE_LOAD:  q_nxt = d;
            MODE_COUNT: q_nxt = q + ONE;
            default:    q_nxt = q;
        endcase
    end

    generate
        if (ASYNC_RST) begin : g_areg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= q_nxt;
            end
        end else begin : g_sreg
            always_ff @(posedge clk) begin
                q <= q_nxt;
            end
        end
    endgenerate

    // Terminal count is combinational in the trickle enable.
    assign tc = cet & (q == ALL_ONES);

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COUNT && q == ALL_ONES) |=> (q == '0)); // R1

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOAD) |=> (q == $past(d))); // R5

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(q)); // R6

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COUNT && q != ALL_ONES) |=> (q == $past(q) + ONE)); // R6

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import cascade_counter_pkg::*;
#(
    parameter int STAGE_W   = 4,
    parameter int STAGES    = 2,
    parameter bit ASYNC_RST = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_n,
    input  logic                       cnt_en_p,
    input  logic                       cnt_en_t,
    input  logic [STAGE_W*STAGES-1:0]  data_in,
    output logic [STAGE_W*STAGES-1:0]  count_out,
    output logic                       carry_out
);
    localparam int TOTAL_W = STAGE_W * STAGES;

    logic [STAGES:0] trickle;

    assign trickle[0] = cnt_en_t;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            stage_ctl_t ctl;
            cnt_mode_e  mode;

            assign ctl.load_n = load_n;
            assign ctl.cen_p  = cnt_en_p;
            assign ctl.cen_t  = trickle[i];

            cnt_mode_dec #(.ASYNC_RST(ASYNC_RST)) u_dec (
                .rst_n (rst_n),
                .ctl   (ctl),
                .mode  (mode)
            );

            cnt_nibble_stage #(.W(STAGE_W), .ASYNC_RST(ASYNC_RST)) u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .mode  (mode),
                .d     (data_in[i*STAGE_W +: STAGE_W]),
                .cet   (trickle[i]),
                .q     (count_out[i*STAGE_W +: STAGE_W]),
                .tc    (trickle[i+1])
            );
        end
    endgenerate

    assign carry_out = trickle[STAGES];

    AST_CARRY_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (cnt_en_t && count_out == {TOTAL_W{1'b1}})); // R7

    AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en_p && cnt_en_t) |=> (count_out == TOTAL_W'($past(count_out) + 1))); // R8

endmodule

// File: tb/cascade_counter_tb_top.sv
`timescale 1ns/1ps
module cascade_counter_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_n = 1'b1;
    logic         cen_p = 1'b0;
    logic         cen_t = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] cnt_s, cnt_a;
    logic         cy_s, cy_a;

    int n_run = 0;
    int n_fail = 0;
    int ref_s = 0;
    int ref_a = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cascade_counter #(.STAGE_W(4), .STAGES(2), .ASYNC_RST(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_p(cen_p),
        .cnt_en_t(cen_t), .data_in(din), .count_out(cnt_s), .carry_out(cy_s));

    cascade_counter #(.STAGE_W(4), .STAGES(2), .ASYNC_RST(1'b1)) dut_a (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_p(cen_p),
        .cnt_en_t(cen_t), .data_in(din), .count_out(cnt_a), .carry_out(cy_a));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=0x%0h expected=0x%0h", tag, $time, act, exp);
        end
    endtask

    function automatic int model_next(input int cur, input bit r, input bit ld,
                                      input bit p, input bit t, input int dv);
        if (!r)           return 0;
        else if (!ld)     return dv;
        else if (p && t)  return (cur + 1) % 256;
        else              return cur;
    endfunction

    function automatic int exp_carry(input int cur, input bit t);
        return (t && cur == 255) ? 1 : 0;
    endfunction

    // Called at a falling edge: drive, check between edges, then check after the rising edge.
    task automatic tick(input bit r, input bit ld, input bit p, input bit t, input int dv);
        string tag;
        rst_n = r; load_n = ld; cen_p = p; cen_t = t; din = W'(dv);
        if (!r) ref_a = 0;
        #2;
        chk(int'(cnt_a) == ref_a, r ? "R9" : "R3", int'(cnt_a), ref_a);
        chk(int'(cnt_s) == ref_s, r ? "R9" : "R4", int'(cnt_s), ref_s);
        chk(int'(cy_s) == exp_carry(ref_s, t), "R7", int'(cy_s), exp_carry(ref_s, t));
        chk(int'(cy_a) == exp_carry(ref_a, t), "R7", int'(cy_a), exp_carry(ref_a, t));
        if (!r)                         tag = ld ? "R4" : "R2";
        else if (!ld)                   tag = "R5";
        else if (!(p && t))             tag = "R6";
        else if (ref_s == 255)          tag = "R1";
        else if ((ref_s % 16) == 15)    tag = "R8";
        else                            tag = "R6";
        @(posedge clk);
        ref_s = model_next(ref_s, r, ld, p, t, dv);
        ref_a = model_next(ref_a, r, ld, p, t, dv);
        @(negedge clk);
        chk(int'(cnt_s) == ref_s, tag, int'(cnt_s), ref_s);
        chk(int'(cnt_a) == ref_a, tag, int'(cnt_a), ref_a);
        chk(int'(cy_s) == exp_carry(ref_s, t), "R7", int'(cy_s), exp_carry(ref_s, t));
        chk(int'(cy_a) == exp_carry(ref_a, t), "R7", int'(cy_a), exp_carry(ref_a, t));
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // Reset state, both variants (R4, R2)
        tick(0, 1, 0, 0, 0);
        tick(0, 0, 1, 1, 8'h3C);
        // Plain counting through 0x0F -> 0x10 (R6, R8)
        for (int i = 0; i < 20; i++) tick(1, 1, 1, 1, 0);
        // Hold with either enable low (R6)
        for (int i = 0; i < 3; i++) tick(1, 1, 0, 1, 8'h77);
        for (int i = 0; i < 3; i++) tick(1, 1, 1, 0, 8'h77);
        // Load overrides count, and loads with enables low (R5)
        tick(1, 0, 1, 1, 8'hA5);
        tick(1, 0, 0, 0, 8'h5A);
        // Terminal count and full wrap (R7, R1)
        tick(1, 0, 1, 1, 8'hFE);
        tick(1, 1, 1, 1, 0);
        tick(1, 1, 1, 1, 0);
        tick(1, 1, 1, 1, 0);
        // At all ones: trickle enable toggled between edges (R7)
        tick(1, 0, 0, 1, 8'hFF);
        tick(1, 1, 0, 0, 0);
        tick(1, 1, 0, 1, 0);
        tick(1, 1, 1, 0, 0);
        // Stage-boundary carry from a preset (R8)
        tick(1, 0, 0, 0, 8'h2F);
        tick(1, 1, 1, 1, 0);
        tick(1, 1, 1, 0, 8'hEF);
        tick(1, 1, 1, 1, 0);
        // Reset beats load: async clears between edges, sync at the edge (R2, R3, R4)
        tick(1, 0, 0, 0, 8'hC3);
        tick(0, 0, 1, 1, 8'h99);
        // Count from zero, then mixed stimulus
        for (int i = 0; i < 300; i++) begin
            int v;
            v = $urandom % 64;
            tick((v % 29) != 0, (v % 7) != 0, (v % 5) != 0, (v % 11) != 0, $urandom % 256);
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule